// File: doc/BRIEF.md
# Dual-Register Capture Timer

The block is a 16-bit up-counter with two capture registers. The counter advances either on the rising phase of a count-clock level input or on each valid-edge strobe from pin 0. Two trigger sources, the already-filtered edge strobes of pin 0 and pin 1, load the running count into capture register 0 and capture register 1. Each register has its own one-cycle interrupt request. A trigger is held pending until the count clock's next falling phase, when the count is sampled. The interrupt for that capture follows on the count clock's next rising phase.

A reverse-phase mode changes the routing.

- Register 0 is loaded on the opposite edge of pin 0, reported by its own strobe, and that capture raises no interrupt.
- A pin 1 edge no longer captures anything. It raises the register-0 request, so it serves as an external interrupt.

When pin 0 is the counting source, pin 0 can no longer trigger captures. A disable input holds the counter at zero and drops any pending work.

Top module: `dcap_timer`

## Requirements
- R1: After reset both capture outputs read 0, both interrupt requests are low, and the counter is 0.
- R2: While enabled, the counter increments once per count-clock rising phase when `src_sel_i`=0, or once per `p0_edge_i` strobe when `src_sel_i`=1. It wraps from 0xFFFF to 0x0000.
- R3: While `run_i` is low the counter is held at 0, and pending triggers and pending interrupts are discarded.
- R4: A trigger is held until the next falling phase of the count clock, which is a cycle where `tck_i` is 0 after having been 1. The register then takes the count held in that cycle, and the new value is visible one cycle later.
- R5: An interrupt earned at a falling phase is output as a one-cycle pulse on the cycle after the next rising phase, which is a cycle where `tck_i` is 1 after having been 0. Bit 0 belongs to register 0 and bit 1 to register 1.
- R6: Several triggers of one channel before the same falling phase give a single capture and a single interrupt pulse.
- R7: With `src_sel_i`=1, pin 0 strobes never capture into register 0 and never raise its interrupt.
- R8: With `rev_mode_i`=1, register 0 captures on `p0_opp_i` and raises no interrupt for it, and `p0_edge_i` does not capture. With `rev_mode_i`=0, `p0_opp_i` is ignored.
- R9: With `rev_mode_i`=1, a `p1_edge_i` strobe leaves register 1 unchanged and raises no bit-1 request. It produces a bit-0 request on the rising phase that follows the next falling phase.
- R10: When `irq_mask_i[k]` is 1, bit k of `irq_o` stays low. Captures still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Timer enable; low clears the counter |
| tck_i | input | 1 | Count-clock level, sampled on clk_i |
| src_sel_i | input | 1 | Count source: 0 count clock, 1 pin 0 edge strobes |
| rev_mode_i | input | 1 | Reverse-phase mode enable |
| p0_edge_i | input | 1 | Pin 0 valid-edge strobe (filtered) |
| p0_opp_i | input | 1 | Pin 0 opposite-edge strobe (filtered) |
| p1_edge_i | input | 1 | Pin 1 valid-edge strobe (filtered) |
| irq_mask_i | input | 2 | Per-request mask, bit k masks irq_o[k] |
| cap0_o | output | 16 | Capture register 0 |
| cap1_o | output | 16 | Capture register 1 |
| irq_o | output | 2 | Interrupt request pulses |

## Verification
A corrupted count shows up in the next capture value, one cycle after the falling phase that samples it. A lost or stale pending flag shows up as a missing or extra capture at that same falling phase, or as a wrong interrupt pulse one cycle after the following rising phase. The check therefore lands within one count-clock period of the fault. Routing faults in reverse-phase or pin-0-source mode appear as a register 1 that changes when it should hold, or as an interrupt on the wrong bit. The stimulus sets up each of these in turn, and a 65536-step run drives the wrap.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned N_CHAN = 2;

  typedef enum logic {
    SRC_TCK  = 1'b0,
    SRC_PIN0 = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/dcap_phase.sv
module dcap_phase (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tck_i,
  output logic rise_o,
  output logic fall_o
);
  logic tck_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) tck_q <= 1'b0;
    else          tck_q <= tck_i;
  end

  assign rise_o = tck_i & ~tck_q;
  assign fall_o = ~tck_i & tck_q;
endmodule

// File: rtl/dcap_counter.sv
module dcap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         run_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)     cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> (cnt_o == '0));

  // R2: one step per increment, wrapping at the top
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && inc_i) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));
endmodule

// File: rtl/dcap_chan.sv
module dcap_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         run_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         cap_trig_i,
  input  logic         cap_irq_en_i,
  input  logic         ext_trig_i,
  input  logic         mask_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cap_o,
  output logic         irq_o
);
  logic [W-1:0] cap_q, cap_d;
  logic         pcap_q, pcap_d;
  logic         pirq_q, pirq_d;
  logic         wait_q, wait_d;
  logic         irq_q, irq_d;
  logic         take_cap, take_irq;

  assign take_cap = pcap_q | cap_trig_i;
  assign take_irq = pirq_q | (cap_trig_i & cap_irq_en_i) | ext_trig_i;

  always_comb begin
    cap_d  = cap_q;
    pcap_d = pcap_q;
    pirq_d = pirq_q;
    wait_d = wait_q;
    irq_d  = 1'b0;
    if (!run_i) begin
      pcap_d = 1'b0;
      pirq_d = 1'b0;
      wait_d = 1'b0;
    end else if (fall_i) begin
      if (take_cap) cap_d = cnt_i;
      wait_d = wait_q | take_irq;
      pcap_d = 1'b0;
      pirq_d = 1'b0;
    end else begin
      pcap_d = take_cap;
      pirq_d = take_irq;
      if (rise_i) begin
        irq_d  = wait_q & ~mask_i;
        wait_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cap_q  <= '0;
      pcap_q <= 1'b0;
      pirq_q <= 1'b0;
      wait_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      pcap_q <= pcap_d;
      pirq_q <= pirq_d;
      wait_q <= wait_d;
      irq_q  <= irq_d;
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;

  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    irq_o |=> !irq_o);

  assert_irq_after_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    irq_o |-> $past(rise_i));

  assert_cap_at_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cap_o != $past(cap_o)) |-> $past(fall_i));

  assert_masked_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(mask_i) |-> !irq_o);
endmodule

// File: rtl/dcap_timer.sv
module dcap_timer
  import dcap_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         run_i,
  input  logic         tck_i,
  input  logic         src_sel_i,
  input  logic         rev_mode_i,
  input  logic         p0_edge_i,
  input  logic         p0_opp_i,
  input  logic         p1_edge_i,
  input  logic [1:0]   irq_mask_i,
  output logic [W-1:0] cap0_o,
  output logic [W-1:0] cap1_o,
  output logic [1:0]   irq_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_n;
  logic         rise, fall, inc;
  logic [W-1:0] cnt;
  logic         src_pin0;
  logic [N_CHAN-1:0] cap_trig, cap_irq_en, ext_trig, irq_w;
  logic [W-1:0] cap_w [N_CHAN];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign src_pin0 = (cnt_src_e'(src_sel_i) == SRC_PIN0);

  dcap_phase u_phase (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .tck_i   (tck_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign inc = src_pin0 ? p0_edge_i : rise;

  dcap_counter #(.W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .run_i   (run_i),
    .inc_i   (inc),
    .cnt_o   (cnt)
  );

  // Trigger routing: reverse-phase mode moves register 0 to the opposite edge
  // and turns pin 1 into an external request on channel 0.
  assign cap_trig[0]   = run_i & ~src_pin0 & (rev_mode_i ? p0_opp_i : p0_edge_i);
  assign cap_irq_en[0] = ~rev_mode_i;
  assign ext_trig[0]   = run_i & rev_mode_i & p1_edge_i;
  assign cap_trig[1]   = run_i & ~rev_mode_i & p1_edge_i;
  assign cap_irq_en[1] = 1'b1;
  assign ext_trig[1]   = 1'b0;

  for (genvar k = 0; k < N_CHAN; k++) begin : g_chan
    dcap_chan #(.W(W)) u_chan (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n),
      .run_i        (run_i),
      .rise_i       (rise),
      .fall_i       (fall),
      .cap_trig_i   (cap_trig[k]),
      .cap_irq_en_i (cap_irq_en[k]),
      .ext_trig_i   (ext_trig[k]),
      .mask_i       (irq_mask_i[k]),
      .cnt_i        (cnt),
      .cap_o        (cap_w[k]),
      .irq_o        (irq_w[k])
    );
  end

  assign cap0_o = cap_w[0];
  assign cap1_o = cap_w[1];
  assign irq_o  = irq_w;
endmodule

// File: tb/dcap_timer_tb_top.sv
`timescale 1ns/1ps
module dcap_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, run, tck, src, rev, p0e, p0o, p1;
  logic [1:0]  mask;
  logic [15:0] cap0, cap1;
  logic [1:0]  irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dcap_timer dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .run_i(run), .tck_i(tck), .src_sel_i(src),
    .rev_mode_i(rev), .p0_edge_i(p0e), .p0_opp_i(p0o), .p1_edge_i(p1),
    .irq_mask_i(mask), .cap0_o(cap0), .cap1_o(cap1), .irq_o(irq)
  );

  // row: tck | p0e p0o p1 rev | irq[1:0] | cap0 | cap1
  localparam logic [38:0] VEC [24] = '{
    {1'b1, 4'b0000, 2'b00, 16'd0, 16'd0},
    {1'b1, 4'b1000, 2'b00, 16'd0, 16'd0},
    {1'b0, 4'b0000, 2'b00, 16'd1, 16'd0},
    {1'b1, 4'b0000, 2'b01, 16'd1, 16'd0},
    {1'b1, 4'b0000, 2'b00, 16'd1, 16'd0},
    {1'b0, 4'b0010, 2'b00, 16'd1, 16'd2},
    {1'b1, 4'b0000, 2'b10, 16'd1, 16'd2},
    {1'b1, 4'b1000, 2'b00, 16'd1, 16'd2},
    {1'b1, 4'b1000, 2'b00, 16'd1, 16'd2},
    {1'b0, 4'b0000, 2'b00, 16'd3, 16'd2},
    {1'b1, 4'b0000, 2'b01, 16'd3, 16'd2},
    {1'b0, 4'b1010, 2'b00, 16'd4, 16'd4},
    {1'b1, 4'b0000, 2'b11, 16'd4, 16'd4},
    {1'b1, 4'b1001, 2'b00, 16'd4, 16'd4},
    {1'b0, 4'b0001, 2'b00, 16'd4, 16'd4},
    {1'b1, 4'b0001, 2'b00, 16'd4, 16'd4},
    {1'b1, 4'b0101, 2'b00, 16'd4, 16'd4},
    {1'b0, 4'b0001, 2'b00, 16'd6, 16'd4},
    {1'b1, 4'b0001, 2'b00, 16'd6, 16'd4},
    {1'b1, 4'b0011, 2'b00, 16'd6, 16'd4},
    {1'b0, 4'b0001, 2'b00, 16'd6, 16'd4},
    {1'b1, 4'b0001, 2'b01, 16'd6, 16'd4},
    {1'b0, 4'b0100, 2'b00, 16'd6, 16'd4},
    {1'b1, 4'b0000, 2'b00, 16'd6, 16'd4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // one system cycle: drive after the falling clock edge, sample after the next one
  task automatic cyc(input logic t, input logic e0, input logic o0, input logic e1);
    tck = t; p0e = e0; p0o = o0; p1 = e1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; tck = 1'b0; src = 1'b0; rev = 1'b0;
    p0e = 1'b0; p0o = 1'b0; p1 = 1'b0; mask = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cap0", 32'(cap0), 32'd0);
    check("R1 cap1", 32'(cap1), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);

    run = 1'b1;
    for (int i = 0; i < 24; i++) begin
      rev = VEC[i][34];
      cyc(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35]);
      check($sformatf("R4/R5/R6/R8/R9 row %0d irq", i), 32'(irq), 32'(VEC[i][33:32]));
      check($sformatf("R4/R6/R8 row %0d cap0", i), 32'(cap0), 32'(VEC[i][31:16]));
      check($sformatf("R4/R9 row %0d cap1", i), 32'(cap1), 32'(VEC[i][15:0]));
    end
    rev = 1'b0;

    // R10: masked request stays low, capture still happens (count is 9)
    mask = 2'b01;
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 cap0 still loads", 32'(cap0), 32'd9);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R10 irq masked", 32'(irq), 32'd0);
    mask = 2'b00;

    // R7 / R2: pin 0 as count source (count 10 -> 11)
    src = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 pin0 counting", 32'(cap1), 32'd11);
    check("R7 cap0 untouched", 32'(cap0), 32'd9);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 no irq0, irq1 only", 32'(irq), 32'd2);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 rise ignored with pin0 source", 32'(cap1), 32'd11);

    // R3: disable drops the pending interrupt and clears the count
    run = 1'b0;
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 pending irq dropped", 32'(irq), 32'd0);
    run = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 count cleared", 32'(cap1), 32'd0);

    // R2: wrap at the top of the range
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 65535; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 full count", 32'(cap1), 32'hFFFF);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 wrap to zero", 32'(cap1), 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule